// File: doc/BRIEF.md
# Two-Layer Pixel Compositor

This block merges two window layers into one RGB pixel stream. Layer 0 is the bottom layer and layer 1 sits on top of it; a small top layer can serve as a cursor. Each cycle, a timing generator supplies the raster position, and fetch logic upstream supplies one raw 32-bit pixel word for each layer. Each layer has its own configuration: an enable, an on-screen rectangle given as origin plus width and height, and a pixel format code. The block decodes each word into 8-bit channels and tests whether the raster position falls inside each rectangle. It then blends the two layers over a black backdrop and registers the result. A pixel entering the block appears at the output two clocks later.

Formats that carry alpha blend with the alpha value taken from the pixel itself. All other formats are drawn opaque. A colour key can be set for layer 1 only. When a layer 1 pixel matches the key, it becomes fully transparent and the layer beneath shows through. The block also tells the fetch logic, for each layer, whether a 16-word burst may be used. This choice depends on the buffer line width.

Top module: `ovl_compositor`

## Requirements
- R1: While rst_ni is low, pix_o is 0x000000.
- R2: pix_o reflects the inputs sampled two rising clock edges earlier. It is 0x000000 wherever no enabled layer covers the raster position.
- R3: A layer covers columns x through last_x, both ends included, where last_x = x+w-1. If x+w is 0, last_x is 0. Rows follow the same rule with y and h. With w=0 and x>0, no column is covered.
- R4: The 32-bit formats without alpha use codes 1 to 4. In each, one byte is ignored, and byte 3 is bits [31:24]. Code 1 puts R,G,B in bytes 2,1,0. Code 2 puts B,G,R in bytes 2,1,0. Code 3 puts R,G,B in bytes 3,2,1. Code 4 puts B,G,R in bytes 3,2,1.
- R5: Code 0 is RGB565, with R in bits [15:11], G in [10:5] and B in [4:0]. Each channel widens to 8 bits by copying its top bits into the vacant low bits.
- R6: Codes 5 to 8 carry alpha: 5 is ARGB, 6 is ABGR, 7 is RGBA and 8 is BGRA, in byte order from byte 3 down to byte 0. Each channel of the result is round((a*fg + (255-a)*bg)/255). Formats without alpha use a=0xFF.
- R7: When key_en_i is high and the decoded layer 1 RGB equals key_val_i, layer 1 takes a=0x00 at that pixel. The key never affects layer 0.
- R8: Format codes 9 to 15 decode exactly as code 8.
- R9: burst_long_o[k] is 1 when win_line_i[k] is at least 128 pixels, and 0 otherwise (8-word bursts). The result for one layer does not depend on the other layer.
- R10: Layer 1 is blended over the result of layer 0 over black. An opaque layer 1 pixel replaces layer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pos_x_i | input | 12 | Raster column |
| pos_y_i | input | 12 | Raster row |
| win_en_i | input | 2 | Layer enables, bit k for layer k |
| win_x_i | input | 2x12 | Rectangle left column per layer |
| win_y_i | input | 2x12 | Rectangle top row per layer |
| win_w_i | input | 2x12 | Rectangle width per layer |
| win_h_i | input | 2x12 | Rectangle height per layer |
| win_fmt_i | input | 2x4 | Pixel format code per layer |
| win_pix_i | input | 2x32 | Raw pixel word per layer |
| win_line_i | input | 2x14 | Buffer line width in pixels (width plus padding) per layer |
| key_en_i | input | 1 | Colour key enable for layer 1 |
| key_val_i | input | 24 | Colour key value, {R,G,B} |
| pix_o | output | 24 | Composited pixel, {R,G,B} |
| burst_long_o | output | 2 | 1 selects 16-word bursts, 0 selects 8-word bursts, per layer |

## Verification
Every format is driven with asymmetric byte patterns, so a swapped or shifted channel shows up as a wrong value. The RGB565 cases use low-order patterns that show whether the widening copies the high bits into the low bits. The alpha tests use mid-range values whose exact result depends on the rounding rule; fully opaque and fully clear values confirm that each end reproduces one layer exactly. Raster positions sit on rectangle edges, one step past an edge, and on zero-size rectangles, to separate inclusive corner handling from off-by-one faults. Key tests are run on both layers to show that only the top layer reacts.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int NUM_WIN = 2;
  localparam int PIX_W   = 32;
  localparam int FMT_W   = 4;
  localparam int RGB_W   = 24;

  typedef enum logic [FMT_W-1:0] {
    FMT_RGB565 = 4'd0,
    FMT_XRGB   = 4'd1,
    FMT_XBGR   = 4'd2,
    FMT_RGBX   = 4'd3,
    FMT_BGRX   = 4'd4,
    FMT_ARGB   = 4'd5,
    FMT_ABGR   = 4'd6,
    FMT_RGBA   = 4'd7,
    FMT_BGRA   = 4'd8
  } fmt_e;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } argb_t;

  localparam logic [7:0] ALPHA_CLEAR = 8'h00;
  localparam logic [7:0] ALPHA_SOLID = 8'hFF;
endpackage

// File: rtl/ovl_unpack.sv
module ovl_unpack
  import ovl_pkg::*;
#(
  parameter bit HAS_KEY = 1'b0
) (
  input  logic [FMT_W-1:0] fmt_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             key_en_i,
  input  logic [RGB_W-1:0] key_val_i,
  output argb_t            px_o
);
  logic [7:0] b3, b2, b1, b0;
  argb_t dec;

  assign {b3, b2, b1, b0} = pix_i;

  always_comb begin
    dec = '0;
    case (fmt_e'(fmt_i))
      FMT_RGB565: begin
        dec.a = ALPHA_SOLID;
        dec.r = {pix_i[15:11], pix_i[15:13]};
        dec.g = {pix_i[10:5],  pix_i[10:9]};
        dec.b = {pix_i[4:0],   pix_i[4:2]};
      end
      FMT_XRGB: dec = '{a: ALPHA_SOLID, r: b2, g: b1, b: b0};
      FMT_XBGR: dec = '{a: ALPHA_SOLID, r: b0, g: b1, b: b2};
      FMT_RGBX: dec = '{a: ALPHA_SOLID, r: b3, g: b2, b: b1};
      FMT_BGRX: dec = '{a: ALPHA_SOLID, r: b1, g: b2, b: b3};
      FMT_ARGB: dec = '{a: b3, r: b2, g: b1, b: b0};
      FMT_ABGR: dec = '{a: b3, r: b0, g: b1, b: b2};
      FMT_RGBA: dec = '{a: b0, r: b3, g: b2, b: b1};
      default:  dec = '{a: b0, r: b1, g: b2, b: b3};  // BGRA and unknown codes
    endcase
  end

  generate
    if (HAS_KEY) begin : g_key
      logic key_hit;
      assign key_hit = key_en_i && ({dec.r, dec.g, dec.b} == key_val_i);
      assign px_o = key_hit ? '{a: ALPHA_CLEAR, r: dec.r, g: dec.g, b: dec.b} : dec;
    end else begin : g_nokey
      logic unused_key;
      assign unused_key = ^{key_en_i, key_val_i};
      assign px_o = dec;
    end
  endgenerate
endmodule

// File: rtl/ovl_hit.sv
module ovl_hit #(
  parameter int COORD_W = 12
) (
  input  logic               en_i,
  input  logic [COORD_W-1:0] pos_x_i,
  input  logic [COORD_W-1:0] pos_y_i,
  input  logic [COORD_W-1:0] org_x_i,
  input  logic [COORD_W-1:0] org_y_i,
  input  logic [COORD_W-1:0] ext_w_i,
  input  logic [COORD_W-1:0] ext_h_i,
  output logic               hit_o
);
  localparam int SUM_W = COORD_W + 1;

  logic [1:0][COORD_W-1:0] pos, org, ext;
  logic [1:0]              in_axis;

  assign pos = {pos_y_i, pos_x_i};
  assign org = {org_y_i, org_x_i};
  assign ext = {ext_h_i, ext_w_i};

  for (genvar ax = 0; ax < 2; ax++) begin : g_axis
    logic [SUM_W-1:0] sum, last;
    assign sum  = {1'b0, org[ax]} + {1'b0, ext[ax]};
    assign last = (sum == '0) ? '0 : sum - 1'b1;  // inclusive far edge, clamped
    assign in_axis[ax] = (pos[ax] >= org[ax]) && ({1'b0, pos[ax]} <= last);
  end

  assign hit_o = en_i && (&in_axis);
endmodule

// File: rtl/ovl_blend.sv
module ovl_blend
  import ovl_pkg::*;
(
  input  logic [7:0]       alpha_i,
  input  logic [RGB_W-1:0] fg_i,
  input  logic [RGB_W-1:0] bg_i,
  output logic [RGB_W-1:0] mix_o
);
  localparam int ACC_W = 18;
  localparam int NCH   = RGB_W / 8;

  logic [7:0] inv;
  assign inv = 8'd255 - alpha_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] quo;
    // acc = a*fg + (255-a)*bg + 128; exact round-to-nearest divide by 255
    assign acc = ACC_W'(alpha_i) * ACC_W'(fg_i[8*c +: 8])
               + ACC_W'(inv) * ACC_W'(bg_i[8*c +: 8]) + ACC_W'(128);
    assign quo = (acc + (acc >> 8)) >> 8;
    assign mix_o[8*c +: 8] = quo[7:0];
  end
endmodule

// File: rtl/ovl_burst.sv
module ovl_burst #(
  parameter int LINE_W        = 14,
  parameter int BURST_MIN_PIX = 128
) (
  input  logic [LINE_W-1:0] line_i,
  output logic              long_o
);
  localparam logic [LINE_W:0] MIN_PIX = (LINE_W+1)'(BURST_MIN_PIX);
  assign long_o = {1'b0, line_i} >= MIN_PIX;
endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
  import ovl_pkg::*;
#(
  parameter int COORD_W       = 12,
  parameter int LINE_W        = 14,
  parameter int BURST_MIN_PIX = 128
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [COORD_W-1:0]                pos_x_i,
  input  logic [COORD_W-1:0]                pos_y_i,
  input  logic [NUM_WIN-1:0]                win_en_i,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   win_x_i,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   win_y_i,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   win_w_i,
  input  logic [NUM_WIN-1:0][COORD_W-1:0]   win_h_i,
  input  logic [NUM_WIN-1:0][FMT_W-1:0]     win_fmt_i,
  input  logic [NUM_WIN-1:0][PIX_W-1:0]     win_pix_i,
  input  logic [NUM_WIN-1:0][LINE_W-1:0]    win_line_i,
  input  logic                              key_en_i,
  input  logic [RGB_W-1:0]                  key_val_i,
  output logic [RGB_W-1:0]                  pix_o,
  output logic [NUM_WIN-1:0]                burst_long_o
);
  argb_t [NUM_WIN-1:0] px_d, px_q;
  logic  [NUM_WIN-1:0] hit_d, hit_q;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    ovl_unpack #(.HAS_KEY(w != 0)) u_unpack (
      .fmt_i     (win_fmt_i[w]),
      .pix_i     (win_pix_i[w]),
      .key_en_i  (key_en_i),
      .key_val_i (key_val_i),
      .px_o      (px_d[w])
    );

    ovl_hit #(.COORD_W(COORD_W)) u_hit (
      .en_i    (win_en_i[w]),
      .pos_x_i (pos_x_i),
      .pos_y_i (pos_y_i),
      .org_x_i (win_x_i[w]),
      .org_y_i (win_y_i[w]),
      .ext_w_i (win_w_i[w]),
      .ext_h_i (win_h_i[w]),
      .hit_o   (hit_d[w])
    );

    ovl_burst #(.LINE_W(LINE_W), .BURST_MIN_PIX(BURST_MIN_PIX)) u_burst (
      .line_i (win_line_i[w]),
      .long_o (burst_long_o[w])
    );
  end

  // stage 1: decoded pixels and coverage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      px_q  <= '0;
      hit_q <= '0;
    end else begin
      px_q  <= px_d;
      hit_q <= hit_d;
    end
  end

  // stage 2: bottom layer over black, then top layer over that
  logic [RGB_W-1:0] base_mix, base, top_mix, comp;

  ovl_blend u_blend_base (
    .alpha_i (px_q[0].a),
    .fg_i    ({px_q[0].r, px_q[0].g, px_q[0].b}),
    .bg_i    ('0),
    .mix_o   (base_mix)
  );

  assign base = hit_q[0] ? base_mix : '0;

  ovl_blend u_blend_top (
    .alpha_i (px_q[1].a),
    .fg_i    ({px_q[1].r, px_q[1].g, px_q[1].b}),
    .bg_i    (base),
    .mix_o   (top_mix)
  );

  assign comp = hit_q[1] ? top_mix : base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_o <= '0;
    else         pix_o <= comp;
  end
endmodule

// File: rtl/ovl_compositor_chk.sv
module ovl_compositor_chk
  import ovl_pkg::*;
#(
  parameter int COORD_W       = 12,
  parameter int LINE_W        = 14,
  parameter int BURST_MIN_PIX = 128
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [NUM_WIN-1:0]             win_en_i,
  input logic [NUM_WIN-1:0][FMT_W-1:0]  win_fmt_i,
  input logic [NUM_WIN-1:0][PIX_W-1:0]  win_pix_i,
  input logic [NUM_WIN-1:0][LINE_W-1:0] win_line_i,
  input logic                           key_en_i,
  input logic [RGB_W-1:0]               key_val_i,
  input logic [RGB_W-1:0]               pix_o,
  input logic [NUM_WIN-1:0]             burst_long_o
);
  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        age <= '0;
    else if (age != 2)  age <= age + 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_dark: assert (pix_o == '0);
  end

  a_r2_dark_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2 && $past(win_en_i, 2) == '0) |-> pix_o == '0);

  a_r7_key_hides_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2 && $past(win_en_i == 2'b10 && key_en_i &&
                       win_fmt_i[1] == FMT_XRGB &&
                       win_pix_i[1][RGB_W-1:0] == key_val_i, 2)) |-> pix_o == '0);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_burst
    a_r9_short_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ({1'b0, win_line_i[w]} < (LINE_W+1)'(BURST_MIN_PIX)) |-> !burst_long_o[w]);
    a_r9_long_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ({1'b0, win_line_i[w]} >= (LINE_W+1)'(BURST_MIN_PIX)) |-> burst_long_o[w]);
  end
endmodule

bind ovl_compositor ovl_compositor_chk #(
  .COORD_W(COORD_W), .LINE_W(LINE_W), .BURST_MIN_PIX(BURST_MIN_PIX)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .win_en_i     (win_en_i),
  .win_fmt_i    (win_fmt_i),
  .win_pix_i    (win_pix_i),
  .win_line_i   (win_line_i),
  .key_en_i     (key_en_i),
  .key_val_i    (key_val_i),
  .pix_o        (pix_o),
  .burst_long_o (burst_long_o)
);

// File: tb/ovl_compositor_test.sv
module ovl_compositor_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int LW = 14;

  logic                 clk_i = 1'b0;
  logic                 rst_ni;
  logic [CW-1:0]        pos_x_i, pos_y_i;
  logic [1:0]           win_en_i;
  logic [1:0][CW-1:0]   win_x_i, win_y_i, win_w_i, win_h_i;
  logic [1:0][3:0]      win_fmt_i;
  logic [1:0][31:0]     win_pix_i;
  logic [1:0][LW-1:0]   win_line_i;
  logic                 key_en_i;
  logic [23:0]          key_val_i;
  logic [23:0]          pix_o;
  logic [1:0]           burst_long_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ovl_compositor uut (.*);

  task automatic check_pix(string tag, logic [23:0] exp);
    checks++;
    if (pix_o !== exp) begin
      errors++;
      $display("FAIL %s pix actual=%06h expected=%06h", tag, pix_o, exp);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic put_win(int w, bit en, int x, int y, int wd, int ht,
                         logic [3:0] fmt, logic [31:0] pix);
    win_en_i[w]  = en;
    win_x_i[w]   = CW'(x);
    win_y_i[w]   = CW'(y);
    win_w_i[w]   = CW'(wd);
    win_h_i[w]   = CW'(ht);
    win_fmt_i[w] = fmt;
    win_pix_i[w] = pix;
  endtask

  // called at a falling edge; output is sampled two rising edges later
  task automatic probe(int x, int y);
    pos_x_i = CW'(x);
    pos_y_i = CW'(y);
    @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    check_pix("R1 reset", 24'h000000);
  endtask

  task automatic t_outside;
    put_win(0, 1, 10, 10, 20, 10, 4'd1, 32'hAA112233);
    put_win(1, 1, 20, 15, 4, 4, 4'd1, 32'h00445566);
    probe(5, 5);    check_pix("R2 outside both", 24'h000000);
    put_win(0, 0, 10, 10, 20, 10, 4'd1, 32'hAA112233);
    put_win(1, 0, 20, 15, 4, 4, 4'd1, 32'h00445566);
    probe(21, 16);  check_pix("R2 disabled layers", 24'h000000);
  endtask

  task automatic t_rect;
    put_win(0, 1, 10, 10, 20, 10, 4'd1, 32'hAA112233);
    probe(10, 10);  check_pix("R3 top-left", 24'h112233);
    probe(29, 19);  check_pix("R3 bottom-right inclusive", 24'h112233);
    probe(30, 19);  check_pix("R3 past right", 24'h000000);
    probe(29, 20);  check_pix("R3 past bottom", 24'h000000);
    probe(9, 12);   check_pix("R3 before left", 24'h000000);
    put_win(0, 1, 0, 0, 0, 0, 4'd1, 32'h00ABCDEF);
    probe(0, 0);    check_pix("R3 zero size clamps to origin", 24'hABCDEF);
    probe(1, 0);    check_pix("R3 zero size col 1", 24'h000000);
    put_win(0, 1, 5, 0, 0, 4, 4'd1, 32'h00ABCDEF);
    probe(5, 1);    check_pix("R3 zero width", 24'h000000);
  endtask

  task automatic t_formats32;
    put_win(0, 1, 0, 0, 64, 64, 4'd2, 32'hEE112233);
    probe(3, 3);    check_pix("R4 xBGR", 24'h332211);
    put_win(0, 1, 0, 0, 64, 64, 4'd3, 32'h112233EE);
    probe(3, 3);    check_pix("R4 RGBx", 24'h112233);
    put_win(0, 1, 0, 0, 64, 64, 4'd4, 32'h112233EE);
    probe(3, 3);    check_pix("R4 BGRx", 24'h332211);
    put_win(0, 1, 0, 0, 64, 64, 4'd1, 32'h00112233);
    probe(3, 3);    check_pix("R4 xRGB ignores pad", 24'h112233);
  endtask

  task automatic t_rgb565;
    put_win(0, 1, 0, 0, 64, 64, 4'd0, 32'hFFFFF800);
    probe(2, 2);    check_pix("R5 red full", 24'hFF0000);
    put_win(0, 1, 0, 0, 64, 64, 4'd0, 32'h00000841);
    probe(2, 2);    check_pix("R5 low bits", 24'h080808);
    put_win(0, 1, 0, 0, 64, 64, 4'd0, 32'h000007E0);
    probe(2, 2);    check_pix("R5 green full", 24'h00FF00);
  endtask

  task automatic t_alpha;
    put_win(1, 0, 0, 0, 0, 0, 4'd1, 32'h0);
    put_win(0, 1, 0, 0, 64, 64, 4'd5, 32'h80FF0000);
    probe(4, 4);    check_pix("R6 ARGB half over black", 24'h800000);
    put_win(0, 1, 0, 0, 64, 64, 4'd6, 32'h80112233);
    probe(4, 4);    check_pix("R6 ABGR rounding", 24'h1A1109);
    put_win(0, 1, 0, 0, 64, 64, 4'd7, 32'h11223380);
    probe(4, 4);    check_pix("R6 RGBA rounding", 24'h09111A);
    put_win(0, 1, 0, 0, 64, 64, 4'd8, 32'h11223380);
    probe(4, 4);    check_pix("R6 BGRA rounding", 24'h1A1109);
    put_win(0, 1, 0, 0, 64, 64, 4'd5, 32'hFF123456);
    probe(4, 4);    check_pix("R6 alpha solid", 24'h123456);
    put_win(0, 1, 0, 0, 64, 64, 4'd5, 32'h00123456);
    probe(4, 4);    check_pix("R6 alpha clear", 24'h000000);
  endtask

  task automatic t_stack;
    put_win(0, 1, 10, 10, 20, 10, 4'd1, 32'h000000FF);
    put_win(1, 1, 20, 15, 4, 4, 4'd5, 32'h40FF0000);
    probe(20, 15);  check_pix("R10 top blends over bottom", 24'h4000BF);
    probe(24, 15);  check_pix("R10 beside top shows bottom", 24'h0000FF);
    put_win(1, 1, 20, 15, 4, 4, 4'd1, 32'h00123456);
    probe(23, 18);  check_pix("R10 opaque top replaces", 24'h123456);
    put_win(0, 0, 10, 10, 20, 10, 4'd1, 32'h000000FF);
    put_win(1, 1, 20, 15, 4, 4, 4'd5, 32'h80FFFFFF);
    probe(21, 16);  check_pix("R10 top over black", 24'h808080);
  endtask

  task automatic t_key;
    key_en_i  = 1'b1;
    key_val_i = 24'h123456;
    put_win(0, 1, 10, 10, 20, 10, 4'd1, 32'h000000FF);
    put_win(1, 1, 20, 15, 4, 4, 4'd1, 32'h00123456);
    probe(21, 16);  check_pix("R7 keyed top transparent", 24'h0000FF);
    put_win(1, 1, 20, 15, 4, 4, 4'd1, 32'h00123457);
    probe(21, 16);  check_pix("R7 near-miss stays opaque", 24'h123457);
    put_win(1, 0, 20, 15, 4, 4, 4'd1, 32'h0);
    put_win(0, 1, 10, 10, 20, 10, 4'd1, 32'h00123456);
    probe(21, 16);  check_pix("R7 bottom ignores key", 24'h123456);
    key_en_i = 1'b0;
    put_win(0, 1, 10, 10, 20, 10, 4'd1, 32'h000000FF);
    put_win(1, 1, 20, 15, 4, 4, 4'd1, 32'h00123456);
    probe(21, 16);  check_pix("R7 key disabled", 24'h123456);
  endtask

  task automatic t_unknown;
    put_win(1, 0, 0, 0, 0, 0, 4'd1, 32'h0);
    put_win(0, 1, 0, 0, 64, 64, 4'd12, 32'h11223380);
    probe(6, 6);    check_pix("R8 code 12 as BGRA", 24'h1A1109);
    put_win(0, 1, 0, 0, 64, 64, 4'd15, 32'hAABBCCFF);
    probe(6, 6);    check_pix("R8 code 15 as BGRA", 24'hCCBBAA);
  endtask

  task automatic t_burst;
    win_line_i[0] = LW'(127);
    win_line_i[1] = LW'(128);
    #1;
    check_bit("R9 line 127 short", burst_long_o[0], 1'b0);
    check_bit("R9 line 128 long", burst_long_o[1], 1'b1);
    win_line_i[0] = LW'(4000);
    win_line_i[1] = LW'(0);
    #1;
    check_bit("R9 line 4000 long", burst_long_o[0], 1'b1);
    check_bit("R9 line 0 short", burst_long_o[1], 1'b0);
  endtask

  initial begin
    rst_ni = 1'b0;
    pos_x_i = '0; pos_y_i = '0;
    win_en_i = '0; win_x_i = '0; win_y_i = '0; win_w_i = '0; win_h_i = '0;
    win_fmt_i = '0; win_pix_i = '0; win_line_i = '0;
    key_en_i = 1'b0; key_val_i = '0;
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_outside;
    t_rect;
    t_formats32;
    t_rgb565;
    t_alpha;
    t_stack;
    t_key;
    t_unknown;
    t_burst;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule